// File: doc/BRIEF.md
# Converter Switching Clock Generator

This block produces the switching clock for a DC-DC power stage and an ADC clock that is derived from it. The switching clock comes from one of two candidates. One is a local oscillator, which can be shut off. The other is the bus clock, which can be inverted and then divided by a power of two chosen through an encoded field. The ADC clock is a copy of the switching clock. It is produced only while ADC synchronization is enabled, and it can be inverted on its own.

Everything is synchronous to a fast sampling clock `clk`. Both candidate clocks arrive as level inputs and are registered once. Source, oscillator shut-off, bus inversion and divider code form a single configuration word. A new configuration is only adopted while the switching clock is low and the new candidate is also low, and the output is held low for the cycle in which the change lands. A configuration change therefore never cuts a pulse short.

Top module: `swclk_gen`

## Requirements
- R1: While `rst_n` is low, both `sw_clk_o` and `adc_clk_o` are 0, and the configuration adopted at reset is the oscillator source, undivided, with no inversion.
- R2: With `src_bus_i`=0 and `osc_off_i`=0, `sw_clk_o` follows the oscillator, two `clk` cycles late and with the same high and low times.
- R3: With `src_bus_i`=1 and `div_code_i`=0, `sw_clk_o` at each cycle equals the bus clock level two `clk` cycles earlier.
- R4: With `bus_inv_i`=1, the bus path uses the complement of the bus clock, so under R3 conditions `sw_clk_o` is the inverse of the bus level two cycles earlier.
- R5: For `div_code_i` values 1, 2, 3 and 4, the bus-sourced `sw_clk_o` has a period of 2, 4, 8 and 16 bus periods, with high and low times equal.
- R6: `div_code_i` values 5, 6 and 7 divide by 16, the same as code 4.
- R7: When the oscillator is selected and `osc_off_i`=1, `sw_clk_o` stays 0. With the bus selected, `osc_off_i` has no effect on `sw_clk_o`.
- R8: A change of source, shut-off, inversion or divider is adopted only in a cycle where `sw_clk_o` is 0, and `sw_clk_o` is 0 in the following cycle as well. Given candidates with half periods of at least two cycles, no pulse of `sw_clk_o` is shorter than two cycles.
- R9: With `adc_sync_i`=1, `adc_clk_o` equals `sw_clk_o` XOR `adc_inv_i` in the same cycle, where `adc_inv_i` is the value sampled one edge earlier.
- R10: With `adc_sync_i`=0, `adc_clk_o` is 0 one cycle later, whatever the value of `adc_inv_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock for all state |
| rst_n | input | 1 | Active-low synchronous reset |
| osc_clk_i | input | 1 | Local oscillator level |
| bus_clk_i | input | 1 | Bus clock level |
| src_bus_i | input | 1 | 0 selects the oscillator, 1 selects the bus clock |
| osc_off_i | input | 1 | 1 shuts off the oscillator path |
| div_code_i | input | 3 | Bus divider code: 0 to 4 give divide by 1, 2, 4, 8, 16; 5 to 7 give divide by 16 |
| bus_inv_i | input | 1 | 1 inverts the bus clock before division |
| adc_sync_i | input | 1 | 1 enables the ADC clock output |
| adc_inv_i | input | 1 | 1 inverts the ADC clock |
| sw_clk_o | output | 1 | Switching clock |
| adc_clk_o | output | 1 | ADC clock |

## Verification
In the bench the bus clock has a period of four cycles and the oscillator a period of six. A measured period therefore shows at once which source is driving the output and which divider code is in effect. The reserved codes are measured against code 4. Under divide-by-one, the output is compared cycle by cycle against the bus level. This tells true from inverted routing and confirms the two-cycle latency, which a period measurement cannot show. A stress phase flips source and divider at irregular moments while every pulse length is watched for runts. The ADC output is compared against the switching clock for all four combinations of its enable and inversion bits.

// File: rtl/swclk_pkg.sv
package swclk_pkg;

  localparam int unsigned DIV_CODE_W = 3;

  // Configuration word that is swapped as a whole at a low phase.
  typedef struct packed {
    logic                  src_bus;
    logic                  osc_off;
    logic                  bus_inv;
    logic [DIV_CODE_W-1:0] div_code;
  } swclk_cfg_t;

  // Map a divider code to a counter stage; codes past the top stage clamp.
  function automatic int unsigned div_stage(input logic [DIV_CODE_W-1:0] code,
                                            input int unsigned max_stage);
    int unsigned c;
    c = 32'(code);
    return (c > max_stage) ? max_stage : c;
  endfunction

  // Candidate level for a given configuration.
  function automatic logic oscillator_level(input logic osc_lvl, input logic shut_off);
    return osc_lvl & ~shut_off;
  endfunction

endpackage

// File: rtl/swclk_bus_div.sv
module swclk_bus_div #(
  parameter int unsigned MAX_STAGE = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_lvl_i,
  input  logic               inv_i,
  output logic [MAX_STAGE:0] taps_o,
  output logic               rise_o
);

  logic                 eff;
  logic                 eff_q;
  logic [MAX_STAGE-1:0] cnt_q;

  // Optional inversion happens before edge detection and division.
  assign eff    = bus_lvl_i ^ inv_i;
  assign rise_o = eff & ~eff_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      eff_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      eff_q <= eff;
      if (rise_o) cnt_q <= cnt_q + 1'b1;
    end
  end

  // Tap 0 is the undivided clock; tap k toggles every 2^(k-1) rising edges.
  assign taps_o[0] = eff;
  for (genvar k = 1; k <= MAX_STAGE; k++) begin : g_tap
    assign taps_o[k] = cnt_q[k-1];
  end

endmodule

// File: rtl/swclk_cfg_gate.sv
module swclk_cfg_gate
  import swclk_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  swclk_cfg_t req_i,
  input  logic       out_low_i,
  input  logic       req_cand_i,
  output swclk_cfg_t act_o,
  output logic       take_o
);

  swclk_cfg_t act_q;
  logic       differs;

  assign differs = (req_i != act_q);
  // Adopt the request only while the output and the new candidate are both low.
  assign take_o  = differs && out_low_i && !req_cand_i;
  assign act_o   = act_q;

  always_ff @(posedge clk) begin
    if (!rst_n) act_q <= '0;
    else if (take_o) act_q <= req_i;
  end

endmodule

// File: rtl/swclk_gen.sv
module swclk_gen
  import swclk_pkg::*;
#(
  parameter int unsigned MAX_STAGE = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  osc_clk_i,
  input  logic                  bus_clk_i,
  input  logic                  src_bus_i,
  input  logic                  osc_off_i,
  input  logic [DIV_CODE_W-1:0] div_code_i,
  input  logic                  bus_inv_i,
  input  logic                  adc_sync_i,
  input  logic                  adc_inv_i,
  output logic                  sw_clk_o,
  output logic                  adc_clk_o
);

  localparam int unsigned TAP_N   = MAX_STAGE + 1;
  localparam int unsigned STAGE_W = $clog2(TAP_N);

  logic             osc_q, bus_q;
  logic [TAP_N-1:0] taps, req_taps;
  logic             bus_rise;
  swclk_cfg_t       req_cfg, act_cfg;
  logic             cfg_take;     // event: configuration adopted this cycle
  logic             hold_low;     // state: disabled oscillator is the source
  logic             act_cand, req_cand;
  logic [STAGE_W-1:0] act_stage, req_stage;
  logic             sw_next, adc_next;
  logic             sw_q, adc_q;

  // Candidate clocks are registered once before use.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      osc_q <= 1'b0;
      bus_q <= 1'b0;
    end else begin
      osc_q <= osc_clk_i;
      bus_q <= bus_clk_i;
    end
  end

  assign req_cfg = '{src_bus: src_bus_i, osc_off: osc_off_i,
                     bus_inv: bus_inv_i, div_code: div_code_i};

  swclk_bus_div #(.MAX_STAGE(MAX_STAGE)) u_div (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_lvl_i(bus_q),
    .inv_i    (act_cfg.bus_inv),
    .taps_o   (taps),
    .rise_o   (bus_rise)
  );

  // The requested inversion may differ from the active one; correct tap 0.
  always_comb begin
    req_taps    = taps;
    req_taps[0] = taps[0] ^ (req_cfg.bus_inv ^ act_cfg.bus_inv);
  end

  assign act_stage = STAGE_W'(div_stage(act_cfg.div_code, MAX_STAGE));
  assign req_stage = STAGE_W'(div_stage(req_cfg.div_code, MAX_STAGE));

  assign act_cand = act_cfg.src_bus ? taps[act_stage]
                                    : oscillator_level(osc_q, act_cfg.osc_off);
  assign req_cand = req_cfg.src_bus ? req_taps[req_stage]
                                    : oscillator_level(osc_q, req_cfg.osc_off);

  swclk_cfg_gate u_gate (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_i     (req_cfg),
    .out_low_i (!sw_q),
    .req_cand_i(req_cand),
    .act_o     (act_cfg),
    .take_o    (cfg_take)
  );

  assign hold_low = !act_cfg.src_bus && act_cfg.osc_off;

  // The cycle a switch lands the output is forced low, stretching the low phase.
  assign sw_next  = cfg_take ? 1'b0 : act_cand;
  assign adc_next = adc_sync_i & (sw_next ^ adc_inv_i);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sw_q  <= 1'b0;
      adc_q <= 1'b0;
    end else begin
      sw_q  <= sw_next;
      adc_q <= adc_next;
    end
  end

  assign sw_clk_o  = sw_q;
  assign adc_clk_o = adc_q;

endmodule

// File: rtl/swclk_gen_chk.sv
module swclk_gen_chk (
  input logic clk,
  input logic rst_n,
  input logic adc_sync_i,
  input logic adc_inv_i,
  input logic sw_clk_o,
  input logic adc_clk_o,
  input logic cfg_take,
  input logic hold_low
);

  assert_take_in_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_take |-> !sw_clk_o);

  assert_take_then_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_take |=> !sw_clk_o);

  assert_osc_off_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
    hold_low |=> !sw_clk_o);

  assert_adc_follow_R9: assert property (@(posedge clk) disable iff (!rst_n)
    adc_sync_i |=> (adc_clk_o == (sw_clk_o ^ $past(adc_inv_i))));

  assert_adc_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !adc_sync_i |=> !adc_clk_o);

endmodule

bind swclk_gen swclk_gen_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .adc_sync_i(adc_sync_i),
  .adc_inv_i (adc_inv_i),
  .sw_clk_o  (sw_clk_o),
  .adc_clk_o (adc_clk_o),
  .cfg_take  (cfg_take),
  .hold_low  (hold_low)
);

// File: tb/swclk_gen_test.sv
`timescale 1ns/1ps
module swclk_gen_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       osc = 1'b0, bus = 1'b0;
  logic       src = 1'b0, off = 1'b0, binv = 1'b0, async_en = 1'b1, ainv = 1'b1;
  logic [2:0] div = 3'd0;
  logic       sw, adc;

  int checks = 0;
  int errors = 0;
  int runts  = 0;
  bit watch_on = 1'b0;
  bit busy = 1'b0;

  typedef struct { string tag; int hi; int lo; } item_t;
  item_t sbq[$];

  always #4 clk = ~clk;

  swclk_gen uut (
    .clk(clk), .rst_n(rst_n), .osc_clk_i(osc), .bus_clk_i(bus),
    .src_bus_i(src), .osc_off_i(off), .div_code_i(div), .bus_inv_i(binv),
    .adc_sync_i(async_en), .adc_inv_i(ainv), .sw_clk_o(sw), .adc_clk_o(adc)
  );

  // Bus clock: half period 2 cycles; oscillator: half period 3 cycles.
  initial begin
    for (int n = 0; n < 1000000; n++) begin
      @(negedge clk);
      bus = ((n / 2) % 2) == 1;
      osc = ((n / 3) % 2) == 1;
    end
  end

  task automatic sample();
    @(posedge clk);
    #2;
  endtask

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic set_cfg(logic s, logic o, logic i, logic [2:0] d);
    @(negedge clk);
    src = s; off = o; binv = i; div = d;
    repeat (100) @(negedge clk);
  endtask

  // Driver side of the scoreboard: push an expected period and wait for it.
  task automatic expect_period(string tag, int hi, int lo);
    item_t it;
    it.tag = tag; it.hi = hi; it.lo = lo;
    sbq.push_back(it);
    wait (sbq.size() == 0 && !busy);
  endtask

  // Monitor: pop an expectation and measure one full period of sw.
  initial begin
    forever begin
      item_t it;
      int h, l;
      wait (sbq.size() > 0);
      it = sbq.pop_front();
      busy = 1'b1;
      h = 0; l = 0;
      sample();
      while (sw !== 1'b0) sample();
      while (sw !== 1'b1) sample();
      while (sw === 1'b1) begin h++; sample(); end
      while (sw === 1'b0) begin l++; sample(); end
      check(it.tag, "high cycles", h, it.hi);
      check(it.tag, "low cycles", l, it.lo);
      busy = 1'b0;
    end
  end

  // Runt watch for R8: every completed pulse must last at least two cycles.
  initial begin
    logic prev;
    int   run;
    bit   started;
    wait (watch_on);
    sample();
    prev = sw; run = 1; started = 1'b0;
    forever begin
      sample();
      if (sw === prev) run++;
      else begin
        if (started && run < 2) runts++;
        started = 1'b1;
        run = 1;
        prev = sw;
      end
    end
  end

  // R3/R4: sw at this sample equals bus seen at the previous sample (xor inv).
  task automatic check_follow(string req, logic inv_exp, int n);
    logic prev;
    int   bad;
    bad = 0;
    sample();
    prev = bus;
    for (int k = 0; k < n; k++) begin
      sample();
      if (sw !== (prev ^ inv_exp)) bad++;
      prev = bus;
    end
    check(req, "bus follow mismatches", bad, 0);
  endtask

  // R9/R10: adc is sw xor inversion when enabled, otherwise 0.
  task automatic check_adc(string req, logic en, logic inv, int n);
    int bad;
    bad = 0;
    @(negedge clk);
    async_en = en; ainv = inv;
    repeat (3) sample();
    for (int k = 0; k < n; k++) begin
      sample();
      if (adc !== (en ? (sw ^ inv) : 1'b0)) bad++;
    end
    check(req, "adc mismatches", bad, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog run did not complete actual=0 expected=1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // R1: reset state, with ADC enabled and inverted so a leak would show.
    repeat (6) sample();
    check("R1", "sw in reset", int'(sw), 0);
    check("R1", "adc in reset", int'(adc), 0);
    @(negedge clk);
    rst_n = 1'b1;
    async_en = 1'b0; ainv = 1'b0;
    repeat (20) @(negedge clk);
    watch_on = 1'b1;

    // R1/R2: the reset configuration runs the oscillator undivided.
    expect_period("R2 oscillator source after R1 reset", 3, 3);

    // R3: undivided bus clock, true polarity.
    set_cfg(1'b1, 1'b0, 1'b0, 3'd0);
    expect_period("R3 bus divide by 1", 2, 2);
    check_follow("R3", 1'b0, 24);

    // R4: inverted bus clock.
    set_cfg(1'b1, 1'b0, 1'b1, 3'd0);
    check_follow("R4", 1'b1, 24);

    // R5: power-of-two division, half period = 2 * 2^code cycles.
    for (int c = 1; c <= 4; c++) begin
      set_cfg(1'b1, 1'b0, 1'b1, 3'(c));
      expect_period($sformatf("R5 divider code %0d", c), 2 << c, 2 << c);
    end

    // R6: reserved codes clamp to divide by 16.
    for (int c = 5; c <= 7; c++) begin
      set_cfg(1'b1, 1'b0, 1'b1, 3'(c));
      expect_period($sformatf("R6 divider code %0d", c), 32, 32);
    end

    // R7: shut-off ignored on the bus path.
    set_cfg(1'b1, 1'b1, 1'b0, 3'd0);
    expect_period("R7 bus path with oscillator off", 2, 2);

    // R7: shut-off oscillator selected holds the output low.
    set_cfg(1'b0, 1'b1, 1'b0, 3'd0);
    begin
      int highs;
      highs = 0;
      for (int k = 0; k < 80; k++) begin
        sample();
        if (sw !== 1'b0) highs++;
      end
      check("R7", "high samples with oscillator off", highs, 0);
    end

    // R9/R10: ADC output under all enable/inversion combinations.
    set_cfg(1'b1, 1'b0, 1'b0, 3'd1);
    check_adc("R9", 1'b1, 1'b0, 40);
    check_adc("R9", 1'b1, 1'b1, 40);
    check_adc("R10", 1'b0, 1'b1, 40);
    check_adc("R10", 1'b0, 1'b0, 40);

    // R8: switch source and divider at irregular moments.
    for (int i = 0; i < 24; i++) begin
      @(negedge clk);
      src = ~src;
      off = 1'b0;
      div = 3'(i % 3);
      repeat (5 + i) @(negedge clk);
    end
    repeat (100) @(negedge clk);
    check("R8", "runt pulses", runts, 0);
    expect_period("R8 settles on final source", (src == 1'b1) ? (2 << div) : 3,
                  (src == 1'b1) ? (2 << div) : 3);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule